// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier

This block multiplies two signed two's-complement operands of N bits and returns the full 2N-bit signed product. It does not add one partial product for every multiplier bit. It recodes the multiplier into signed digits taken from overlapping three-bit windows, so each digit covers two multiplier bits. One digit is handled per clock. A single ripple adder/subtractor then adds 0, ±X or ±2X into a running sum, and a full operation takes N/2 steps.

A client raises `start` for one cycle while `busy` is low, with the operands applied at that time. `busy` stays high while the steps run. `done` pulses for one cycle when the result is ready on `product`. The product holds that value until the next operation finishes. A new operation may be started in the same cycle that `done` is high, so operations can run back to back.

Top module: `booth_mul_seq`

## Requirements
- R1: Each step selects its addend from the window (upper, middle, lower) of multiplier bits. Windows 000 and 111 add nothing. Windows 001 and 010 add X. Window 011 adds 2X. Window 100 subtracts 2X. Windows 101 and 110 subtract X.
- R2: The first window uses an implicit 0 as its lower bit. Each later window sits two bit positions above the previous one. The selected multiple is aligned two positions further left on each step.
- R3: One operation performs exactly N/2 add/subtract steps, so `busy` is high for exactly N/2 cycles after `start` is accepted.
- R4: `product` equals the signed product of `mcand` and `mplier`, both taken as two's complement, over the full 2N-bit range. This includes zero and the most negative operand values.
- R5: `done` is high for exactly one cycle. That cycle comes directly after the final step. `busy` is low in that cycle, and `product` already shows the new result.
- R6: `start` has no effect while `busy` is high. The running operation keeps its operands and its length, and no extra `done` pulse follows.
- R7: `start` is accepted in the cycle where `done` is high. `busy` is then high in the next cycle.
- R8: `product` changes only on the clock edge that raises `done`. In all other cycles it holds its value.
- R9: After reset, `busy` is 0, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while `busy` is low) |
| mcand | input | N | Multiplicand X, two's complement |
| mplier | input | N | Multiplier Y, two's complement |
| busy | output | 1 | High while recoded steps are being processed |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 2N | Signed product, held until the next completion |

## Verification
Two events can meet in one cycle: a new `start` can arrive in the very cycle that `done` reports the previous result, and it can also arrive on the final step while `busy` is still high. The bench triggers both cases. It issues operations back to back, so that each new `start` lines up with the preceding `done`. It also holds `start` high, with different operands, through every step of a running operation, including the last one. The scoreboard then requires one correct product for each accepted start and no extra `done` pulse. Separate checks confirm that `busy` is high in the cycle after a start made during `done`.

// File: rtl/booth_pkg.sv
package booth_pkg;
   // Decoded radix-4 digit: magnitude selects plus sign
   typedef struct packed {
      logic one;   // magnitude 1
      logic two;   // magnitude 2
      logic neg;   // subtract the multiple
   } booth_sel_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic [2:0]  grp,
   output booth_sel_t  sel
);
   always_comb begin
      sel.one = grp[1] ^ grp[0];
      sel.two = (grp == 3'b011) | (grp == 3'b100);
      // a zero digit (000 or 111) never requests subtraction
      sel.neg = grp[2] & ~(grp[1] & grp[0]);
   end

   // R1: digit magnitude is 0, 1 or 2 and a negated digit is never zero
   always_comb begin
      assert_digit_legal_R1: assert ($onehot0({sel.one, sel.two}) &&
                                     !(sel.neg && !sel.one && !sel.two));
   end
endmodule

// File: rtl/booth_multiple.sv
module booth_multiple
   import booth_pkg::*;
#(
   parameter int W = 34
) (
   input  logic [W-1:0] base,
   input  booth_sel_t   sel,
   output logic [W-1:0] addend
);
   always_comb begin
      if (sel.two)      addend = {base[W-2:0], 1'b0};
      else if (sel.one) addend = base;
      else              addend = '0;
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
   parameter int W = 34
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum
);
   logic [W-1:0] b_x;
   logic [W-1:0] carry;

   // subtraction: flip every addend bit and inject a carry of one
   assign b_x      = b ^ {W{sub}};
   assign carry[0] = sub;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i] = a[i] ^ b_x[i] ^ carry[i];
      if (i < W - 1) begin : g_cy
         assign carry[i+1] = (a[i] & b_x[i]) | (carry[i] & (a[i] ^ b_x[i]));
      end
   end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step_en,
   output logic last
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

   logic [CW-1:0] cnt_q;

   assign load    = start & ~busy;
   assign step_en = busy;
   assign last    = busy & (cnt_q == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= last;
         if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
   import booth_pkg::*;
#(
   parameter int N = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N-1:0]   mcand,
   input  logic [N-1:0]   mplier,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);
   localparam int STEPS = N / 2;
   localparam int W     = 2 * N + 2;
   localparam int RW    = $clog2(STEPS + 1) + 1;

   if ((N % 2) != 0 || N < 4) begin : g_bad_width
      $error("booth_mul_seq: N must be even and at least 4");
   end

   logic           load, step_en, last;
   logic [W-1:0]   mc_q;      // sign-extended multiplicand, pre-aligned
   logic [N:0]     yq;        // multiplier with implicit zero below LSB
   logic [W-1:0]   acc_q;
   logic [W-1:0]   addend, sum;
   logic [2*N-1:0] prod_q;
   booth_sel_t     sel;

   booth_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk, .rst_n, .start,
      .busy, .done, .load, .step_en, .last
   );

   booth_recoder u_rec (
      .grp (yq[2:0]),
      .sel (sel)
   );

   booth_multiple #(.W(W)) u_mult (
      .base   (mc_q),
      .sel    (sel),
      .addend (addend)
   );

   booth_addsub #(.W(W)) u_add (
      .a   (acc_q),
      .b   (addend),
      .sub (sel.neg),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc_q   <= '0;
         yq     <= '0;
         acc_q  <= '0;
         prod_q <= '0;
      end else if (load) begin
         mc_q  <= {{(W-N){mcand[N-1]}}, mcand};
         yq    <= {mplier, 1'b0};
         acc_q <= '0;
      end else if (step_en) begin
         acc_q <= sum;
         mc_q  <= {mc_q[W-3:0], 2'b00};
         yq    <= {2'b00, yq[N:2]};
         if (last) prod_q <= sum[2*N-1:0];
      end
   end

   assign product = prod_q;

   // ---------------- assertions ----------------
   logic [RW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len <= '0;
      else if (load)    run_len <= '0;
      else if (busy)    run_len <= run_len + 1'b1;
   end

   // R4: the final sum fits the 2N-bit signed range (guard bits agree)
   always_comb begin
      if (rst_n && last) begin
         assert_no_overflow_R4: assert (sum[W-1:2*N-1] == '0 ||
                                        sum[W-1:2*N-1] == '1);
      end
   end

   // R3: completion arrives after exactly STEPS busy cycles
   assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> run_len == RW'(STEPS));

   // R6: a start while busy never stretches or restarts the run
   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_len < RW'(STEPS));

   // R5: done is a single-cycle pulse and never overlaps busy
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: the product only moves on a completion edge
   assert_product_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));
endmodule

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;
   localparam int N      = 8;
   localparam int STEPS  = N / 2;
   localparam int CLK_NS = 10;
   localparam int WDOG   = 150000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N-1:0]   mcand = '0;
   logic [N-1:0]   mplier = '0;
   logic           busy, done;
   logic [2*N-1:0] product;

   int total = 0;
   int bad   = 0;
   int dones = 0;
   int cyc   = 0;

   logic [2*N-1:0] exp_q[$];

   booth_mul_seq #(.N(N)) u_dut (
      .clk, .rst_n, .start, .mcand, .mplier, .busy, .done, .product
   );

   always #(CLK_NS/2) clk = ~clk;

   function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
      logic signed [2*N-1:0] ea, eb;
      ea = signed'({{N{a[N-1]}}, a});
      eb = signed'({{N{b[N-1]}}, b});
      return ea * eb;
   endfunction

   task automatic check(bit ok, string req, longint act, longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // driver: push expectation, pulse start once busy is low
   task automatic launch(logic [N-1:0] a, logic [N-1:0] b);
      @(negedge clk);
      while (busy) @(negedge clk);
      exp_q.push_back(ref_mul(a, b));
      mcand  = a;
      mplier = b;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: compare each completion against the scoreboard (R4, R1, R2)
   always @(negedge clk) begin
      if (rst_n && done) begin
         dones++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected done", 1, 0);
         end else begin
            logic [2*N-1:0] e;
            e = exp_q.pop_front();
            check(product == e, "R4 product", longint'($signed(product)),
                  longint'($signed(e)));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [N-1:0] pick_mc(int k);
      case (k)
         0: return {1'b1, {(N-1){1'b0}}};
         1: return {1'b0, {(N-1){1'b1}}};
         2: return N'(-77);
         default: return N'(3);
      endcase
   endfunction

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9 busy", busy, 0);
      check(done == 1'b0, "R9 done", done, 0);
      check(product == '0, "R9 product", product, 0);
      rst_n = 1'b1;

      // R1 R2: worked case 9 x 7 (subtract X then add 2X shifted)
      launch(N'(9), N'(7));
      drain();
      check(product == 16'd63, "R1 9x7", product, 63);

      // R4 extremes and zero
      launch({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}});
      launch({1'b1, {(N-1){1'b0}}}, {1'b0, {(N-1){1'b1}}});
      launch('1, '1);
      launch('0, N'(-5));
      launch(N'(-5), '0);
      drain();

      // R3: busy lasts exactly STEPS cycles
      begin
         int blen;
         blen = 0;
         launch(N'(13), N'(-11));
         while (busy) begin blen++; @(negedge clk); end
         check(blen == STEPS, "R3 busy length", blen, STEPS);
         check(done == 1'b1, "R5 done after last step", done, 1);
         drain();
      end

      // R8: product holds after done
      begin
         logic [2*N-1:0] held;
         held = product;
         repeat (5) @(negedge clk);
         check(product == held, "R8 hold", product, held);
      end

      // R6: start held through every busy cycle, incl. the final step
      begin
         int d0;
         d0 = dones;
         launch(N'(21), N'(-3));
         mcand  = N'(99);
         mplier = N'(99);
         start  = 1'b1;
         repeat (STEPS) @(negedge clk);
         start  = 1'b0;
         repeat (STEPS + 3) @(negedge clk);
         check(dones - d0 == 1, "R6 single done", dones - d0, 1);
         check(busy == 1'b0, "R6 idle after", busy, 0);
         check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
      end

      // R7: start accepted in the done cycle
      begin
         launch(N'(6), N'(6));
         @(negedge clk);
         while (!done) @(negedge clk);
         exp_q.push_back(ref_mul(N'(-4), N'(25)));
         mcand  = N'(-4);
         mplier = N'(25);
         start  = 1'b1;
         @(negedge clk);
         start  = 1'b0;
         check(busy == 1'b1, "R7 busy after done-cycle start", busy, 1);
         drain();
      end

      // R1 R2 R4: every multiplier value against several multiplicands
      for (int k = 0; k < 4; k++) begin
         for (int v = 0; v < (1 << N); v++) begin
            launch(pick_mc(k), N'(v));
         end
      end
      drain();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule